// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

This block is a down-counting timer that sits beside a local interrupt dispatcher. Software sets a starting count, a prescaler ratio and a repeat mode through a small 32-bit register port. The count then falls by one for every prescaled system tick. When it reaches zero, the timer sends a single-cycle expiry strobe to the dispatcher. The dispatcher owns masking, vector selection and delivery. The timer only reports that its period has elapsed.

Writing the starting count arms the timer. That write also copies the value into the live count and restarts the prescaler, so the first period is exactly the starting count times the divisor, counted in ticks. In repeat mode the live count reloads from the starting count on the same edge that raises the strobe. In single-shot mode it stays at zero and the timer falls quiet. A starting count of zero parks the timer entirely. Software can overwrite the live count at any time without touching the starting count.

Top module: `cd_timer`

## Requirements
- R1: After reset, every register reads as zero and `expire_o` is low.
- R2: A write to offset 0x380 stores the value as the starting count and loads the same value into the live count on the same edge. Both read back from offsets 0x380 and 0x390.
- R3: A write to offset 0x390 replaces only the live count. The starting count is unchanged.
- R4: The divide register at offset 0x3E0 keeps only write-data bits 3, 1 and 0, and reads them back in place with all other bits zero. The code {bit3,bit1,bit0} selects the divisor: 000=/2, 001=/4, 010=/8, 011=/16, 100=/32, 101=/64, 110=/128, 111=/1.
- R5: While `tick_i` is held high, the first expiry after a starting-count write of N with divisor D comes exactly N×D clock edges after the write edge.
- R6: Expiry is a one-cycle high pulse on `expire_o`. It is raised on the edge where a counting step takes the live count from 1 (or 0) to zero.
- R7: In repeat mode, the live count equals the starting count in the same cycle `expire_o` is high, and later expiries follow every N×D edges.
- R8: In single-shot mode, the live count stays at zero after expiry, and no further expiry occurs until the next write.
- R9: While the starting count is zero, the live count holds its value, even a nonzero written value, and no expiry occurs.
- R10: The count and the prescaler advance only in cycles where `tick_i` is high.
- R11: Offset 0x320 holds the mode in bit 17 (1 = repeat, 0 = single-shot), and its other bits read as zero. Reads of any other offset return zero, and writes to them change nothing.
- R12: A register write in a cycle where a counting step would occur takes precedence. The written value is loaded, and no expiry is raised on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | System tick enable feeding the prescaler |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Register byte offset |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for `addr_i` (combinational) |
| expire_o | output | 1 | One-cycle expiry strobe to the interrupt dispatcher |

## Verification
The cycle-level invariants are checked on every cycle:
- loading on a starting-count write;
- the reload value seen in the expiry cycle in each mode;
- expiry only coming from a count of one or zero after a real tick;
- the count being frozen when the timer is idle or unticked;
- writes winning over counting steps.

Only the bench's scenarios can show the period lengths. It sweeps all eight divide codes against several starting counts in both modes, and measures the distance from the arming write to the first expiry and between later expiries. Readback masking, register isolation and the silence of a spent single-shot timer are also shown by those scenarios.

// File: rtl/cd_timer_pkg.sv
package cd_timer_pkg;
  localparam logic [11:0] OFS_MODE = 12'h320;
  localparam logic [11:0] OFS_INIT = 12'h380;
  localparam logic [11:0] OFS_CUR  = 12'h390;
  localparam logic [11:0] OFS_DIV  = 12'h3E0;
  localparam int MODE_BIT = 17;
  localparam int SHIFT_W  = 3;

  // divide code -> log2(divisor); code 7 means divide by one
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [2:0] code);
    return (code == 3'd7) ? '0 : SHIFT_W'(code + 3'd1);
  endfunction
endpackage

// File: rtl/cd_timer_presc.sv
module cd_timer_presc
  import cd_timer_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               restart_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               step_o
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  assign mask   = ~({PRE_W{1'b1}} << shift_i);
  assign step_o = tick_i && !restart_i && ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else if (tick_i)    pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/cd_timer_core.sv
module cd_timer_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic [DATA_W-1:0] init_i,
  input  logic              periodic_i,
  input  logic              step_i,
  output logic [DATA_W-1:0] cur_o,
  output logic              expire_o
);
  logic [DATA_W-1:0] cur_q;
  logic              exp_q;
  logic              active;

  assign active   = (init_i != '0) && (periodic_i || (cur_q != '0));
  assign cur_o    = cur_q;
  assign expire_o = exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      exp_q <= 1'b0;
    end else if (load_i) begin
      cur_q <= load_val_i;
      exp_q <= 1'b0;
    end else if (step_i && active) begin
      if (cur_q <= DATA_W'(1)) begin
        cur_q <= periodic_i ? init_i : '0;
        exp_q <= 1'b1;
      end else begin
        cur_q <= cur_q - 1'b1;
        exp_q <= 1'b0;
      end
    end else begin
      exp_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cd_timer_regs.sv
module cd_timer_regs
  import cd_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cur_i,
  output logic [DATA_W-1:0] init_o,
  output logic              periodic_o,
  output logic [2:0]        div_code_o,
  output logic              init_wr_o,
  output logic              cur_wr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] init_q;
  logic              mode_q;
  logic [2:0]        div_q;
  logic              hit_mode, hit_div;

  assign init_wr_o  = we_i && (addr_i == ADDR_W'(OFS_INIT));
  assign cur_wr_o   = we_i && (addr_i == ADDR_W'(OFS_CUR));
  assign hit_mode   = we_i && (addr_i == ADDR_W'(OFS_MODE));
  assign hit_div    = we_i && (addr_i == ADDR_W'(OFS_DIV));
  assign init_o     = init_q;
  assign periodic_o = mode_q;
  assign div_code_o = div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= '0;
      mode_q <= 1'b0;
      div_q  <= '0;
    end else begin
      if (init_wr_o) init_q <= wdata_i;
      if (hit_mode)  mode_q <= wdata_i[MODE_BIT];
      if (hit_div)   div_q  <= {wdata_i[3], wdata_i[1], wdata_i[0]};
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(OFS_INIT): rdata_o = init_q;
      ADDR_W'(OFS_CUR):  rdata_o = cur_i;
      ADDR_W'(OFS_MODE): rdata_o[MODE_BIT] = mode_q;
      ADDR_W'(OFS_DIV):  rdata_o[3:0] = {div_q[2], 1'b0, div_q[1:0]};
      default:           rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cd_timer.sv
module cd_timer
  import cd_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              expire_o
);
  logic [DATA_W-1:0] init_q, cur_q;
  logic              periodic_q;
  logic [2:0]        div_code;
  logic              init_wr, cur_wr, step;

  cd_timer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .cur_i(cur_q), .init_o(init_q), .periodic_o(periodic_q),
    .div_code_o(div_code), .init_wr_o(init_wr), .cur_wr_o(cur_wr),
    .rdata_o
  );

  cd_timer_presc u_presc (
    .clk_i, .rst_ni, .tick_i,
    .restart_i(init_wr),
    .shift_i(div_shift(div_code)),
    .step_o(step)
  );

  // any write in the cycle blocks the counting step
  cd_timer_core #(.DATA_W(DATA_W)) u_core (
    .clk_i, .rst_ni,
    .load_i(init_wr || cur_wr),
    .load_val_i(wdata_i),
    .init_i(init_q),
    .periodic_i(periodic_q),
    .step_i(step && !we_i),
    .cur_o(cur_q),
    .expire_o
  );
endmodule

// File: rtl/cd_timer_chk.sv
module cd_timer_chk
  import cd_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              expire_o,
  input logic [DATA_W-1:0] init_q,
  input logic [DATA_W-1:0] cur_q,
  input logic              periodic_q
);
  a_r2_init_loads_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(OFS_INIT)) |=>
      (init_q == $past(wdata_i) && cur_q == $past(wdata_i)));

  a_r6_expire_from_low_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> ($past(cur_q) <= DATA_W'(1) && !$past(we_i) && $past(tick_i)));

  a_r7_periodic_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && periodic_q) |-> (cur_q == init_q));

  a_r8_oneshot_rests: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !periodic_q) |-> (cur_q == '0));

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q == '0 && !we_i) |=> ($stable(cur_q) && !expire_o));

  a_r10_no_tick_no_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !tick_i) |=> ($stable(cur_q) && !expire_o));

  a_r12_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> !expire_o);
endmodule

bind cd_timer cd_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .tick_i, .we_i, .addr_i, .wdata_i, .expire_o,
  .init_q, .cur_q, .periodic_q
);

// File: tb/tb_cd_timer.sv
module tb_cd_timer;
  localparam logic [11:0] A_MODE = 12'h320, A_INIT = 12'h380,
                          A_CUR  = 12'h390, A_DIV  = 12'h3E0;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b1, we = 1'b0;
  logic [11:0] addr = A_CUR;
  logic [31:0] wdata = '0, rdata;
  logic        expire;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  cd_timer dut (.clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we),
                .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .expire_o(expire));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; addr = A_CUR;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata; addr = A_CUR;
  endtask

  task automatic edges_to_expire(input int limit, output int n);
    n = 0;
    do begin @(posedge clk); #1 n++; end while (!expire && n < limit);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int n, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_INIT, v); check(v == 0, "R1 init", v, 0);
    rd(A_CUR,  v); check(v == 0, "R1 cur",  v, 0);
    rd(A_MODE, v); check(v == 0, "R1 mode", v, 0);
    rd(A_DIV,  v); check(v == 0, "R1 div",  v, 0);
    check(expire == 0, "R1 expire", expire, 0);

    // R4 / R11 readback masking and unmapped offset
    wr(A_DIV, 32'hFFFF_FFFF);  rd(A_DIV, v);  check(v == 32'hB, "R4 div mask", v, 32'hB);
    wr(A_MODE, 32'hFFFF_FFFF); rd(A_MODE, v); check(v == 32'h0002_0000, "R11 mode mask", v, 32'h0002_0000);
    wr(A_MODE, 0);
    wr(A_INIT, 0);
    wr(12'h3F0, 32'hFFFF_FFFF); rd(12'h3F0, v); check(v == 0, "R11 unmapped read", v, 0);
    rd(A_INIT, v); check(v == 0, "R11 unmapped write isolated", v, 0);

    // R2 / R3 load behaviour, timer held by tick low
    tick = 1'b0;
    wr(A_INIT, 32'd1000);
    rd(A_INIT, v); check(v == 1000, "R2 init readback", v, 1000);
    rd(A_CUR, v);  check(v == 1000, "R2 cur loaded", v, 1000);
    wr(A_CUR, 32'd77);
    rd(A_CUR, v);  check(v == 77, "R3 cur write", v, 77);
    rd(A_INIT, v); check(v == 1000, "R3 init kept", v, 1000);

    // R10 count moves only on tick (divide-by-one)
    wr(A_DIV, 32'hB);
    repeat (10) @(negedge clk);
    rd(A_CUR, v); check(v == 77, "R10 frozen without tick", v, 77);
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    rd(A_CUR, v); check(v == 76, "R10 one tick one step", v, 76);
    tick = 1'b1;

    // R5..R8 sweep: every divide code, two counts, both modes
    for (int c = 0; c < 8; c++) begin
      for (int m = 0; m < 2; m++) begin
        for (int k = 0; k < 2; k++) begin
          automatic int init = (k == 0) ? 1 : 3;
          automatic int dv   = (c == 7) ? 1 : (2 << c);
          automatic int per  = init * dv;
          wr(A_INIT, 0);
          wr(A_DIV, {28'd0, c[2], 1'b0, c[1], c[0]});
          wr(A_MODE, m[0] ? 32'h0002_0000 : 0);
          wr(A_INIT, init);
          edges_to_expire(2000, n);
          check(n == per, "R5 first period", n, per);
          if (m == 1) begin
            check(rdata == init, "R7 reload with strobe", rdata, init);
            for (int r = 0; r < 2; r++) begin
              edges_to_expire(2000, n);
              check(n == per, "R7 repeat period", n, per);
            end
          end else begin
            check(rdata == 0, "R8 rests at zero", rdata, 0);
            @(posedge clk); #1;
            check(expire == 0, "R6 strobe one cycle", expire, 0);
            e = 0;
            for (int r = 0; r < 2 * per + 4; r++) begin
              @(posedge clk); #1 if (expire) e++;
            end
            check(e == 0, "R8 no re-expiry", e, 0);
          end
        end
      end
    end

    // R6 pulse width in repeat mode with period > 1
    wr(A_INIT, 0); wr(A_DIV, 32'hB); wr(A_MODE, 32'h0002_0000);
    wr(A_INIT, 4);
    edges_to_expire(100, n);
    @(posedge clk); #1 check(expire == 0, "R6 periodic pulse width", expire, 0);

    // R9 idle with zero starting count
    wr(A_INIT, 0); wr(A_CUR, 5);
    e = 0;
    for (int r = 0; r < 300; r++) begin @(posedge clk); #1 if (expire) e++; end
    check(e == 0, "R9 no expiry while idle", e, 0);
    rd(A_CUR, v); check(v == 5, "R9 count held", v, 5);

    // R12 write on the edge that would expire
    wr(A_MODE, 0); wr(A_DIV, 32'hB);
    wr(A_INIT, 2);
    wr(A_CUR, 7);
    check(expire == 0, "R12 no expiry on write edge", expire, 0);
    check(rdata == 7, "R12 written value wins", rdata, 7);
    @(posedge clk); #1 check(rdata == 6, "R12 counting resumes", rdata, 6);

    finish_run();
  end
endmodule